// File: doc/BRIEF.md
# Timestamp-LRU Set-Associative Cache

This block is a parameterized cache that serves aligned word loads and word stores from one upstream requester. Its geometry is set by three parameters: the number of sets, the number of ways (lines) in each set, and the line size in bytes. The capacity is sets × ways × line bytes. With one way the block behaves as a direct-mapped cache. With one set it behaves as a fully associative cache.

Each line carries a recency stamp that also serves as its valid flag. A stamp of zero means the line is empty. A nonzero stamp is the access-clock value from the last time the line was used. The access clock advances by one for each accepted request. On a miss, the cache picks an empty way of the indexed set if one exists. Otherwise it picks the way with the oldest stamp. It then requests the whole aligned block from a downstream port, takes the block as a series of word beats, and completes the original access as a hit on the new line. A store that misses allocates in the same way before the word is written. Hit and miss totals are exposed as counters.

Top module: `stamp_cache`

## Requirements
- R1: After reset, every line is empty, both counters read zero, `rsp_valid` is low and `req_ready` is high, so the first access to any address misses.
- R2: A byte address splits into a byte offset in bits [OFF_W-1:0], a set index in the next log2(SETS) bits and a tag in the remaining upper bits. Word accesses are aligned. The word inside a line is selected by offset bits [OFF_W-1:log2(WORD_W/8)]. With the default values (16-bit word, 8-byte line, 4 sets), the set index is bits [4:3] and the tag is bits [15:5].
- R3: A load that hits is accepted in one cycle. `rsp_valid` is high for exactly the following cycle, and `rsp_rdata` holds the word at the addressed offset of the matching line.
- R4: On a miss, `fill_req_valid` rises in the cycle after acceptance and stays high until `fill_req_ready` is seen. `fill_addr` is the request address with the offset bits cleared. The cache then takes LINE_BYTES/(WORD_W/8) beats on `fill_beat_valid`: beat k becomes word k of the line, and idle cycles between beats are allowed. `rsp_valid` rises two cycles after the last beat is taken.
- R5: `req_ready` stays low from the acceptance of a missing request until its response cycle, and is high otherwise.
- R6: On a miss, an empty way is used before any valid way is evicted. When several ways are empty, the lowest-numbered one is used.
- R7: The access clock is 1 after reset and advances on every accepted request. A hit or a fill writes the current clock value into the line's stamp. When no way is empty, the way with the smallest stamp is replaced.
- R8: A store that misses allocates: the block is filled, and then the word is written. The response returns the stored word, and later loads to that block see the stored word together with the filled values of the other words.
- R9: A store that hits replaces only the addressed word of the line and returns the stored word. The other words of the line keep their values.
- R10: Every accepted request increments exactly one of `hit_count` or `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | WORD_W | Store data |
| rsp_valid | output | 1 | Response valid, one cycle per request |
| rsp_rdata | output | WORD_W | Loaded word, or the stored word for a store |
| fill_req_valid | output | 1 | Block-fill request to downstream |
| fill_req_ready | input | 1 | Downstream accepts the fill request |
| fill_addr | output | ADDR_W | Block-aligned fill address |
| fill_beat_valid | input | 1 | Fill data beat present |
| fill_beat_data | input | WORD_W | Fill data word, ascending word order |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
A table-driven stream walks a set that holds two ways through a fixed sequence. The sequence fills an empty way first. It then refreshes one way with hits so that the other way goes stale, and follows with conflicting tags. Each of these accesses tells apart stamp-based replacement from replacement that always evicts the same way, evicts in round robin, or never refreshes a stamp on a hit. Stores that miss and stores that hit, each followed by loads to neighbouring words of the same line, separate write-allocate from write-around and whole-line corruption. Loads to other sets and other word offsets confirm that the index and offset fields are decoded at the right bit positions. Every fill is served with a stalled request handshake and a gap between beats, so early responses, misaligned fill addresses and beats placed in the wrong words are exposed. A reset in the middle of the run shows that all lines are cleared and that both counters return to zero.

// File: rtl/stamp_cache_pkg.sv
package stamp_cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_FILL_REQ  = 2'd1,
      ST_FILL_DATA = 2'd2,
      ST_COMPLETE  = 2'd3
   } ctl_state_t;
endpackage

// File: rtl/stamp_cache_addr.sv
// Splits a word address (byte bits below the word already removed) into
// tag, set index and word-within-line index.
module stamp_cache_addr #(
   parameter int ADDR_W   = 16,
   parameter int WB_W     = 1,
   parameter int OFF_W    = 3,
   parameter int IDX_BITS = 2,
   parameter int IDX_W    = 2,
   parameter int WIDX_W   = 2,
   parameter int TAG_W    = 11
) (
   input  logic [ADDR_W-1:WB_W] word_addr,
   output logic [TAG_W-1:0]     tag,
   output logic [IDX_W-1:0]     idx,
   output logic [WIDX_W-1:0]    widx
);
   assign tag = word_addr[ADDR_W-1 -: TAG_W];

   generate
      if (IDX_BITS > 0) begin : g_idx
         assign idx = word_addr[OFF_W +: IDX_W];
      end else begin : g_no_idx
         assign idx = '0;
      end
      if (OFF_W > WB_W) begin : g_widx
         assign widx = word_addr[WB_W +: WIDX_W];
      end else begin : g_no_widx
         assign widx = '0;
      end
   endgenerate
endmodule

// File: rtl/stamp_cache_match.sv
// Compares a probe tag against every way of one set; only nonzero-stamp ways count.
module stamp_cache_match #(
   parameter int WAYS    = 2,
   parameter int TAG_W   = 11,
   parameter int STAMP_W = 16,
   parameter int WAY_W   = 1
) (
   input  logic [WAYS-1:0][TAG_W-1:0]   way_tags,
   input  logic [WAYS-1:0][STAMP_W-1:0] way_stamps,
   input  logic [TAG_W-1:0]             probe,
   output logic                         hit,
   output logic [WAY_W-1:0]             hit_way,
   output logic [WAYS-1:0]              match_vec
);
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign match_vec[w] = (way_stamps[w] != '0) && (way_tags[w] == probe);
      end
   endgenerate

   always_comb begin
      hit     = |match_vec;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match_vec[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/stamp_cache_victim.sv
// Chooses the way to replace: lowest empty way, else smallest stamp.
module stamp_cache_victim #(
   parameter int WAYS    = 2,
   parameter int STAMP_W = 16,
   parameter int WAY_W   = 1
) (
   input  logic [WAYS-1:0][STAMP_W-1:0] way_stamps,
   output logic [WAY_W-1:0]             victim,
   output logic                         any_free
);
   logic [STAMP_W-1:0] oldest;
   logic [WAY_W-1:0]   oldest_way;
   logic [WAY_W-1:0]   free_way;

   always_comb begin
      any_free = 1'b0;
      free_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!any_free && way_stamps[w] == '0) begin
            any_free = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   always_comb begin
      oldest     = way_stamps[0];
      oldest_way = '0;
      for (int w = 1; w < WAYS; w++) begin
         if (way_stamps[w] < oldest) begin
            oldest     = way_stamps[w];
            oldest_way = WAY_W'(w);
         end
      end
   end

   assign victim = any_free ? free_way : oldest_way;
endmodule

// File: rtl/stamp_cache.sv
module stamp_cache
   import stamp_cache_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int WORD_W     = 16,
   parameter int SETS       = 4,
   parameter int WAYS       = 2,
   parameter int LINE_BYTES = 8,
   parameter int STAMP_W    = 16,
   parameter int CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              fill_req_valid,
   input  logic              fill_req_ready,
   output logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_beat_valid,
   input  logic [WORD_W-1:0] fill_beat_data,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int WPL        = LINE_BYTES / WORD_BYTES;
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int WB_W       = $clog2(WORD_BYTES);
   localparam int IDX_BITS   = $clog2(SETS);
   localparam int IDX_W      = (SETS > 1) ? IDX_BITS : 1;
   localparam int WIDX_W     = (WPL > 1) ? $clog2(WPL) : 1;
   localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_BITS;
   localparam logic [STAMP_W-1:0] STAMP_MAX = '1;

   // elaboration-time parameter checks
   initial begin : cfg_check
      assert (WORD_W >= 8 && WORD_W % 8 == 0 && (WORD_BYTES & (WORD_BYTES - 1)) == 0)
         else $error("WORD_W must be a power-of-two number of bytes");
      assert (LINE_BYTES >= WORD_BYTES && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two of at least one word");
      assert (SETS >= 1 && (SETS & (SETS - 1)) == 0)
         else $error("SETS must be a power of two");
      assert (WAYS >= 1) else $error("WAYS must be at least one");
      assert (TAG_W >= 1) else $error("address too narrow for this geometry");
      assert (STAMP_W >= 2 && CNT_W >= 1) else $error("counter widths too small");
   end

   // storage
   logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
   logic [STAMP_W-1:0] stamp_q [SETS][WAYS];
   logic [WORD_W-1:0]  data_q  [SETS][WAYS][WPL];

   ctl_state_t         st_q;
   logic [STAMP_W-1:0] access_clk;

   // pending miss context
   logic [TAG_W-1:0]   p_tag;
   logic [IDX_W-1:0]   p_idx;
   logic [WIDX_W-1:0]  p_widx;
   logic [WAY_W-1:0]   p_way;
   logic               p_write;
   logic [WORD_W-1:0]  p_wdata;
   logic [STAMP_W-1:0] p_stamp;
   logic [ADDR_W-1:0]  p_base;
   logic [WIDX_W-1:0]  beat_cnt;
   logic               beat_last;

   // lookup
   logic [TAG_W-1:0]   r_tag;
   logic [IDX_W-1:0]   r_idx;
   logic [WIDX_W-1:0]  r_widx;
   logic [WAYS-1:0][TAG_W-1:0]   set_tags;
   logic [WAYS-1:0][STAMP_W-1:0] set_stamps;
   logic               lk_hit;
   logic [WAY_W-1:0]   lk_way;
   logic [WAYS-1:0]    lk_match;
   logic [WAY_W-1:0]   victim;
   logic               any_free;
   logic               accept;
   logic               take_beat;

   assign req_ready      = (st_q == ST_IDLE);
   assign accept         = req_valid && req_ready;
   assign fill_req_valid = (st_q == ST_FILL_REQ);
   assign fill_addr      = p_base;
   assign take_beat      = (st_q == ST_FILL_DATA) && fill_beat_valid;
   assign beat_last      = (beat_cnt == WIDX_W'(WPL - 1));

   stamp_cache_addr #(
      .ADDR_W(ADDR_W), .WB_W(WB_W), .OFF_W(OFF_W), .IDX_BITS(IDX_BITS),
      .IDX_W(IDX_W), .WIDX_W(WIDX_W), .TAG_W(TAG_W)
   ) u_addr (
      .word_addr(req_addr[ADDR_W-1:WB_W]),
      .tag      (r_tag),
      .idx      (r_idx),
      .widx     (r_widx)
   );

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         set_tags[w]   = tag_q[r_idx][w];
         set_stamps[w] = stamp_q[r_idx][w];
      end
   end

   stamp_cache_match #(
      .WAYS(WAYS), .TAG_W(TAG_W), .STAMP_W(STAMP_W), .WAY_W(WAY_W)
   ) u_match (
      .way_tags  (set_tags),
      .way_stamps(set_stamps),
      .probe     (r_tag),
      .hit       (lk_hit),
      .hit_way   (lk_way),
      .match_vec (lk_match)
   );

   stamp_cache_victim #(
      .WAYS(WAYS), .STAMP_W(STAMP_W), .WAY_W(WAY_W)
   ) u_victim (
      .way_stamps(set_stamps),
      .victim    (victim),
      .any_free  (any_free)
   );

   // control, counters, stamps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         access_clk <= STAMP_W'(1);
         hit_count  <= '0;
         miss_count <= '0;
         beat_cnt   <= '0;
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               stamp_q[s][w] <= '0;
      end else begin
         if (accept) begin
            access_clk <= (access_clk == STAMP_MAX) ? STAMP_W'(1) : access_clk + 1'b1;
            if (lk_hit) begin
               hit_count              <= hit_count + 1'b1;
               stamp_q[r_idx][lk_way] <= access_clk;
            end else begin
               miss_count <= miss_count + 1'b1;
            end
         end
         if (take_beat) begin
            beat_cnt <= beat_last ? '0 : beat_cnt + 1'b1;
            if (beat_last) stamp_q[p_idx][p_way] <= p_stamp;
         end
         case (st_q)
            ST_IDLE:      if (accept && !lk_hit) st_q <= ST_FILL_REQ;
            ST_FILL_REQ:  if (fill_req_ready) st_q <= ST_FILL_DATA;
            ST_FILL_DATA: if (take_beat && beat_last) st_q <= ST_COMPLETE;
            default:      st_q <= ST_IDLE;
         endcase
      end
   end

   // response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= (accept && lk_hit) || (st_q == ST_COMPLETE);
         if (accept && lk_hit)
            rsp_rdata <= req_write ? req_wdata : data_q[r_idx][lk_way][r_widx];
         else if (st_q == ST_COMPLETE)
            rsp_rdata <= p_write ? p_wdata : data_q[p_idx][p_way][p_widx];
      end
   end

   // miss context and line contents (no reset needed: guarded by stamps)
   always_ff @(posedge clk) begin
      if (accept && !lk_hit) begin
         p_tag   <= r_tag;
         p_idx   <= r_idx;
         p_widx  <= r_widx;
         p_way   <= victim;
         p_write <= req_write;
         p_wdata <= req_wdata;
         p_stamp <= access_clk;
         p_base  <= {req_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
      end
      if (accept && lk_hit && req_write)
         data_q[r_idx][lk_way][r_widx] <= req_wdata;
      if (take_beat) begin
         data_q[p_idx][p_way][beat_cnt] <= fill_beat_data;
         if (beat_last) tag_q[p_idx][p_way] <= p_tag;
      end
      if (st_q == ST_COMPLETE && p_write)
         data_q[p_idx][p_way][p_widx] <= p_wdata;
   end

   // ---------------- assertions ----------------
   generate
      if (WB_W > 0) begin : g_align_chk
         p_aligned_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_ready) |-> (req_addr[WB_W-1:0] == '0));
      end
   endgenerate

   p_hit_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lk_hit) |=> rsp_valid);

   p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> (fill_addr[OFF_W-1:0] == '0));

   p_miss_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !lk_hit) |=> (fill_req_valid && !req_ready && !rsp_valid));

   p_free_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !lk_hit && any_free) |-> (set_stamps[victim] == '0));

   p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(lk_match));

   p_clock_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      access_clk != '0);

   p_filled_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_COMPLETE) |-> (stamp_q[p_idx][p_way] != '0));

   p_one_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));
endmodule

// File: tb/sim_stamp_cache.sv
module sim_stamp_cache;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 18;

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [15:0] wdata;
      logic        hit;
      logic [15:0] data;
      logic [3:0]  req;
   } vec_t;

   // default geometry: 16-bit words, 8-byte lines, 4 sets, 2 ways;
   // set = addr[4:3], tag = addr[15:5]; fill memory word at a = a ^ 16'hA5C3
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h0002, 16'h0000, 1'b0, 16'hA5C1, 4'd6},  // R6 cold miss, set0 way0
      '{1'b0, 16'h0006, 16'h0000, 1'b1, 16'hA5C5, 4'd3},  // R3 hit other word
      '{1'b0, 16'h0020, 16'h0000, 1'b0, 16'hA5E3, 4'd6},  // R6 empty way1 used
      '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'hA5C3, 4'd7},  // R7 refresh way0
      '{1'b0, 16'h0040, 16'h0000, 1'b0, 16'hA583, 4'd7},  // R7 evict way1 (older)
      '{1'b0, 16'h0004, 16'h0000, 1'b1, 16'hA5C7, 4'd7},  // R7 way0 survived
      '{1'b0, 16'h0022, 16'h0000, 1'b0, 16'hA5E1, 4'd7},  // R7 tag1 was evicted
      '{1'b1, 16'h0108, 16'h1234, 1'b0, 16'h1234, 4'd8},  // R8 store miss allocates
      '{1'b0, 16'h0108, 16'h0000, 1'b1, 16'h1234, 4'd8},  // R8 stored word visible
      '{1'b0, 16'h010A, 16'h0000, 1'b1, 16'hA4C9, 4'd8},  // R8 neighbour from fill
      '{1'b1, 16'h010E, 16'hBEEF, 1'b1, 16'hBEEF, 4'd9},  // R9 store hit
      '{1'b0, 16'h010E, 16'h0000, 1'b1, 16'hBEEF, 4'd9},  // R9 read back
      '{1'b0, 16'h0108, 16'h0000, 1'b1, 16'h1234, 4'd9},  // R9 other word intact
      '{1'b0, 16'h0006, 16'h0000, 1'b1, 16'hA5C5, 4'd7},  // R7 refresh way0 again
      '{1'b0, 16'h0060, 16'h0000, 1'b0, 16'hA5A3, 4'd7},  // R7 evict way1
      '{1'b0, 16'h0002, 16'h0000, 1'b1, 16'hA5C1, 4'd7},  // R7 way0 kept
      '{1'b0, 16'h0030, 16'h0000, 1'b0, 16'hA5F3, 4'd2},  // R2 set2
      '{1'b0, 16'h0018, 16'h0000, 1'b0, 16'hA5DB, 4'd2}   // R2 set3
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        fill_req_valid;
   logic        fill_req_ready = 1'b0;
   logic [15:0] fill_addr;
   logic        fill_beat_valid = 1'b0;
   logic [15:0] fill_beat_data = '0;
   logic [15:0] hit_count;
   logic [15:0] miss_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stamp_cache u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
      .fill_addr(fill_addr), .fill_beat_valid(fill_beat_valid),
      .fill_beat_data(fill_beat_data),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   function automatic logic [15:0] mem_at(input logic [15:0] a);
      return a ^ 16'hA5C3;
   endfunction

   task automatic chk(input bit ok, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // one access; serves the fill if the design asks for one
   task automatic do_access(input logic wr, input logic [15:0] addr,
                            input logic [15:0] wd, input logic exp_hit,
                            input logic [15:0] exp_data, input string tag);
      logic got_hit;
      logic got_rsp;
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R5 ready when idle"}, 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      got_hit = rsp_valid;
      got_rsp = rsp_valid;
      chk(got_hit == exp_hit, {tag, " hit/miss"}, 32'(got_hit), 32'(exp_hit));
      if (!got_hit && fill_req_valid) begin
         chk(req_ready == 1'b0, {tag, " R5 busy during miss"}, 32'(req_ready), 32'd0);
         chk(fill_addr == (addr & 16'hFFF8), {tag, " R4 fill address"},
             32'(fill_addr), 32'(addr & 16'hFFF8));
         repeat (2) @(negedge clk);
         chk(fill_req_valid == 1'b1, {tag, " R4 request held"}, 32'(fill_req_valid), 32'd1);
         fill_req_ready = 1'b1;
         @(posedge clk);
         @(negedge clk);
         fill_req_ready = 1'b0;
         for (int k = 0; k < 4; k++) begin
            if (k == 2) begin
               fill_beat_valid = 1'b0;
               @(posedge clk);
               @(negedge clk);
            end
            fill_beat_valid = 1'b1;
            fill_beat_data  = mem_at((addr & 16'hFFF8) + 16'(2 * k));
            @(posedge clk);
            @(negedge clk);
            fill_beat_valid = 1'b0;
         end
         chk(rsp_valid == 1'b0 && req_ready == 1'b0, {tag, " R4 no early response"},
             32'({rsp_valid, req_ready}), 32'd0);
         @(posedge clk);
         @(negedge clk);
         got_rsp = rsp_valid;
         chk(rsp_valid == 1'b1, {tag, " R4 response after fill"}, 32'(rsp_valid), 32'd1);
      end
      if (got_rsp)
         chk(rsp_rdata == exp_data, {tag, " data"}, 32'(rsp_rdata), 32'(exp_data));
      else
         chk(1'b0, {tag, " no response"}, 32'd0, 32'd1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, {tag, " R3 single response cycle"}, 32'(rsp_valid), 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
      chk(hit_count == 16'd0 && miss_count == 16'd0, "R1 counters zero",
          32'({hit_count, miss_count}), 32'd0);

      for (int i = 0; i < NV; i++) begin
         do_access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].hit, VECS[i].data,
                   $sformatf("R%0d vec%0d", VECS[i].req, i));
      end

      // R10 one count per request: 10 hits, 8 misses in the table
      chk(hit_count == 16'd10, "R10 hit total", 32'(hit_count), 32'd10);
      chk(miss_count == 16'd8, "R10 miss total", 32'(miss_count), 32'd8);

      // R1 reset mid-run clears lines and counters
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hit_count == 16'd0 && miss_count == 16'd0, "R1 counters cleared",
          32'({hit_count, miss_count}), 32'd0);
      do_access(1'b0, 16'h0006, 16'h0000, 1'b0, 16'hA5C5, "R1 line cleared");
      do_access(1'b0, 16'h0002, 16'h0000, 1'b1, 16'hA5C1, "R3 hit after refill");
      chk(hit_count == 16'd1 && miss_count == 16'd1, "R10 totals after reset",
          32'({hit_count, miss_count}), 32'h0001_0001);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule